// File: doc/BRIEF.md
# AXI ID Transaction Filter Counter

This block watches a simplified monitor view of a memory port and counts the transactions whose ID, direction and port number pass a per-counter filter. Each counter has three settings. An event code chooses reads or writes. A compare word holds a 16-bit ID and a 16-bit mask. A mux word holds a port selector and a channel selector for each direction. A counter keeps two totals side by side: the number of matching bursts, and the number of bytes those bursts carry.

The monitor presents one address strobe per transaction and one data strobe per beat. The direction flag, ID, port number and beat byte count travel with each strobe. The mask bits and the channel bits are held in inverted form: a stored mask bit of 0 means the ID bit is compared, and a stored channel bit of 0 turns on the port comparison. Both totals saturate at all-ones and set a sticky overflow flag. A per-counter clear takes priority over everything else.

Top module: `axi_id_filt_cnt`

## Requirements
- R1: After reset, every burst total, byte total and overflow flag reads zero.
- R2: An ID matches when every bit whose stored mask bit (compare word bits 31:16) is 0 equals the stored ID bit (compare word bits 15:0). Bits whose stored mask bit is 1 are ignored.
- R3: Event code 0x41 counts only reads (mon_write_i low) and 0x42 counts only writes. Any other code counts nothing.
- R4: For reads the port selector is mux bits 2:0 and the channel bit is bit 3. For writes the port selector is bits 10:8 and the channel bit is bit 11. A channel bit of 0 requires the port number to equal the selector. A channel bit of 1 ignores the port.
- R5: The burst total rises by exactly one on each address strobe of a matching transaction, and data beats leave it unchanged.
- R6: The byte total adds mon_bytes_i on each data strobe of a matching transaction.
- R7: A total whose true value would exceed all-ones holds at all-ones and sets the counter's overflow flag. The flag stays set until a clear.
- R8: A clear zeroes both totals and the overflow flag on the next edge, even if a matching strobe arrives in the same cycle.
- R9: While a counter's enable is low, its totals and flag hold their values.
- R10: Each counter filters with its own compare and mux words, so one transaction may be counted by some counters and not by others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cmp_i | input | NCNT x 32 | Per counter: inverted mask in bits 31:16, ID in bits 15:0 |
| cfg_mux_i | input | NCNT x 12 | Per counter port and channel selectors, channel bits inverted |
| cfg_evt_i | input | NCNT x 8 | Per counter event code |
| cnt_en_i | input | NCNT | Per counter enable |
| cnt_clr_i | input | NCNT | Per counter clear |
| mon_addr_i | input | 1 | Address strobe of a transaction |
| mon_beat_i | input | 1 | Data beat strobe |
| mon_write_i | input | 1 | 1 = write, 0 = read |
| mon_id_i | input | 16 | Transaction ID |
| mon_port_i | input | 3 | Port number |
| mon_bytes_i | input | BW | Bytes in the current beat |
| burst_cnt_o | output | NCNT x CW | Matching burst totals |
| byte_cnt_o | output | NCNT x CW | Matching byte totals |
| ovf_o | output | NCNT | Sticky overflow flags |

## Verification
The bench builds the block with three counters, 8-bit totals and a 6-bit beat byte field. With these values, the byte total saturates after a few 60-byte beats, and the burst total saturates after a few hundred address-only transactions. Each of the three counters is given a different filter: a full-ID read match, a partly masked write match with a port check, and an all-ignored ID with a read port check. A single stream of traffic therefore shows which counters count it and which do not, along with the mask, the port selection and the direction choice.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam logic [7:0] EV_RD = 8'h41;
  localparam logic [7:0] EV_WR = 8'h42;
  localparam int ID_W   = 16;
  localparam int PORT_W = 3;

  typedef struct packed {
    logic [ID_W-1:0] mask_n;  // 1 = ignore bit
    logic [ID_W-1:0] id;
  } cmp_reg_t;

  typedef struct packed {
    logic              wr_chan_n;  // 0 = port compare on
    logic [PORT_W-1:0] wr_port;
    logic [3:0]        rsvd;
    logic              rd_chan_n;
    logic [PORT_W-1:0] rd_port;
  } mux_reg_t;
endpackage

// File: rtl/axf_match.sv
module axf_match
  import axf_pkg::*;
(
  input  cmp_reg_t          cmp_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic              wr_chan_n_i,
  input  logic [PORT_W-1:0] rd_port_i,
  input  logic              rd_chan_n_i,
  input  logic [7:0]        evt_i,
  input  logic              write_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              hit_o
);
  logic evt_ok, id_ok, port_ok;

  always_comb begin
    evt_ok  = write_i ? (evt_i == EV_WR) : (evt_i == EV_RD);
    id_ok   = ((id_i ^ cmp_i.id) & ~cmp_i.mask_n) == '0;
    port_ok = write_i ? (wr_chan_n_i || (port_i == wr_port_i))
                      : (rd_chan_n_i || (port_i == rd_port_i));
    hit_o   = evt_ok && id_ok && port_ok;
  end
endmodule

// File: rtl/axf_sat_acc.sv
module axf_sat_acc #(
  parameter int CW = 32,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [IW-1:0] inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW:0] sum;

  assign sum   = {1'b0, cnt_o} + {{(CW+1-IW){1'b0}}, inc_i};
  assign ovf_o = add_i & sum[CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (add_i)  cnt_o <= sum[CW] ? '1 : sum[CW-1:0];
  end
endmodule

// File: rtl/axi_id_filt_cnt.sv
module axi_id_filt_cnt
  import axf_pkg::*;
#(
  parameter int NCNT = 3,
  parameter int CW   = 32,
  parameter int BW   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCNT-1:0][31:0]     cfg_cmp_i,
  input  logic [NCNT-1:0][11:0]     cfg_mux_i,
  input  logic [NCNT-1:0][7:0]      cfg_evt_i,
  input  logic [NCNT-1:0]           cnt_en_i,
  input  logic [NCNT-1:0]           cnt_clr_i,
  input  logic                      mon_addr_i,
  input  logic                      mon_beat_i,
  input  logic                      mon_write_i,
  input  logic [15:0]               mon_id_i,
  input  logic [2:0]                mon_port_i,
  input  logic [BW-1:0]             mon_bytes_i,
  output logic [NCNT-1:0][CW-1:0]   burst_cnt_o,
  output logic [NCNT-1:0][CW-1:0]   byte_cnt_o,
  output logic [NCNT-1:0]           ovf_o
);
  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    mux_reg_t mux;
    logic     hit, burst_ovf, byte_ovf;
    logic     burst_add, byte_add;

    assign mux = mux_reg_t'(cfg_mux_i[n]);

    axf_match u_match (
      .cmp_i      (cmp_reg_t'(cfg_cmp_i[n])),
      .wr_port_i  (mux.wr_port),
      .wr_chan_n_i(mux.wr_chan_n),
      .rd_port_i  (mux.rd_port),
      .rd_chan_n_i(mux.rd_chan_n),
      .evt_i      (cfg_evt_i[n]),
      .write_i    (mon_write_i),
      .id_i       (mon_id_i),
      .port_i     (mon_port_i),
      .hit_o      (hit)
    );

    assign burst_add = cnt_en_i[n] && hit && mon_addr_i;
    assign byte_add  = cnt_en_i[n] && hit && mon_beat_i;

    axf_sat_acc #(.CW(CW), .IW(1)) u_burst (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr_i[n]),
      .add_i (burst_add),
      .inc_i (1'b1),
      .cnt_o (burst_cnt_o[n]),
      .ovf_o (burst_ovf)
    );

    axf_sat_acc #(.CW(CW), .IW(BW)) u_byte (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr_i[n]),
      .add_i (byte_add),
      .inc_i (mon_bytes_i),
      .cnt_o (byte_cnt_o[n]),
      .ovf_o (byte_ovf)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ovf_o[n] <= 1'b0;
      else if (cnt_clr_i[n])           ovf_o[n] <= 1'b0;
      else if (burst_ovf || byte_ovf)  ovf_o[n] <= 1'b1;
    end
  end
endmodule

// File: rtl/axi_id_filt_cnt_chk.sv
module axi_id_filt_cnt_chk #(
  parameter int NCNT = 3,
  parameter int CW   = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NCNT-1:0]         cnt_en_i,
  input logic [NCNT-1:0]         cnt_clr_i,
  input logic [NCNT-1:0][CW-1:0] burst_cnt_o,
  input logic [NCNT-1:0][CW-1:0] byte_cnt_o,
  input logic [NCNT-1:0]         ovf_o
);
  for (genvar n = 0; n < NCNT; n++) begin : g_chk
    a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_clr_i[n] |=> (burst_cnt_o[n] == '0) && (byte_cnt_o[n] == '0) && !ovf_o[n]);

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_en_i[n] && !cnt_clr_i[n]) |=>
        $stable(burst_cnt_o[n]) && $stable(byte_cnt_o[n]) && $stable(ovf_o[n]));

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[n] && !cnt_clr_i[n]) |=> ovf_o[n]);

    a_r7_ovf_at_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o[n]) |-> (burst_cnt_o[n] == '1) || (byte_cnt_o[n] == '1));

    a_r7_burst_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((burst_cnt_o[n] == '1) && !cnt_clr_i[n]) |=> (burst_cnt_o[n] == '1));

    a_r5_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_clr_i[n] |=> (burst_cnt_o[n] == $past(burst_cnt_o[n])) ||
                        (burst_cnt_o[n] == $past(burst_cnt_o[n]) + 1'b1));

    a_r6_byte_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_clr_i[n] |=> byte_cnt_o[n] >= $past(byte_cnt_o[n]));
  end
endmodule

bind axi_id_filt_cnt axi_id_filt_cnt_chk #(.NCNT(NCNT), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .cnt_clr_i  (cnt_clr_i),
  .burst_cnt_o(burst_cnt_o),
  .byte_cnt_o (byte_cnt_o),
  .ovf_o      (ovf_o)
);

// File: tb/tb_axi_id_filt_cnt.sv
`timescale 1ns/1ps
module tb_axi_id_filt_cnt;
  localparam int NCNT = 3;
  localparam int CW   = 8;
  localparam int BW   = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [NCNT-1:0][31:0]   cfg_cmp;
  logic [NCNT-1:0][11:0]   cfg_mux;
  logic [NCNT-1:0][7:0]    cfg_evt;
  logic [NCNT-1:0]         en, clr;
  logic                    m_addr, m_beat, m_wr;
  logic [15:0]             m_id;
  logic [2:0]              m_port;
  logic [BW-1:0]           m_bytes;
  logic [NCNT-1:0][CW-1:0] burst, bytes;
  logic [NCNT-1:0]         ovf;

  axi_id_filt_cnt #(.NCNT(NCNT), .CW(CW), .BW(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_cmp_i(cfg_cmp), .cfg_mux_i(cfg_mux),
    .cfg_evt_i(cfg_evt), .cnt_en_i(en), .cnt_clr_i(clr),
    .mon_addr_i(m_addr), .mon_beat_i(m_beat), .mon_write_i(m_wr),
    .mon_id_i(m_id), .mon_port_i(m_port), .mon_bytes_i(m_bytes),
    .burst_cnt_o(burst), .byte_cnt_o(bytes), .ovf_o(ovf));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mb[NCNT], my[NCNT], mo[NCNT];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_hit(int n);
    logic [31:0] c = cfg_cmp[n];
    logic [11:0] x = cfg_mux[n];
    bit use_port;
    int sel;
    if (m_wr && cfg_evt[n] != 8'h42) return 0;
    if (!m_wr && cfg_evt[n] != 8'h41) return 0;
    for (int b = 0; b < 16; b++)
      if (!c[16+b] && (m_id[b] != c[b])) return 0;
    use_port = m_wr ? !x[11] : !x[3];
    sel      = m_wr ? int'(x[10:8]) : int'(x[2:0]);
    if (use_port && int'(m_port) != sel) return 0;
    return 1;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCNT; n++) begin mb[n] = 0; my[n] = 0; mo[n] = 0; end
    end else begin
      for (int n = 0; n < NCNT; n++) begin
        if (clr[n]) begin mb[n] = 0; my[n] = 0; mo[n] = 0; end
        else if (en[n] && m_hit(n)) begin
          if (m_addr) begin
            if (mb[n] + 1 > MAXV) begin mb[n] = MAXV; mo[n] = 1; end else mb[n]++;
          end
          if (m_beat) begin
            if (my[n] + int'(m_bytes) > MAXV) begin my[n] = MAXV; mo[n] = 1; end
            else my[n] += int'(m_bytes);
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done)
    for (int n = 0; n < NCNT; n++) begin
      chk("R5 model burst", int'(burst[n]), mb[n]);
      chk("R6 model bytes", int'(bytes[n]), my[n]);
      chk("R7 model ovf",   int'(ovf[n]),   mo[n]);
    end

  task automatic txn(bit wr, logic [15:0] id, logic [2:0] port, int beats, int nb);
    @(negedge clk);
    m_addr = 1; m_beat = 0; m_wr = wr; m_id = id; m_port = port;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      m_addr = 0; m_beat = 1; m_bytes = BW'(nb);
    end
    @(negedge clk);
    m_addr = 0; m_beat = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    en = '1; clr = '0; m_addr = 0; m_beat = 0; m_wr = 0; m_id = 0; m_port = 0; m_bytes = 0;
    cfg_evt[0] = 8'h41; cfg_cmp[0] = {16'h0000, 16'h1234}; cfg_mux[0] = 12'h008;
    cfg_evt[1] = 8'h42; cfg_cmp[1] = {16'h00FF, 16'h0A00}; cfg_mux[1] = {1'b0, 3'd5, 4'h0, 1'b1, 3'd0};
    cfg_evt[2] = 8'h41; cfg_cmp[2] = {16'hFFFF, 16'h5555}; cfg_mux[2] = {1'b1, 3'd0, 4'h0, 1'b0, 3'd2};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int n = 0; n < NCNT; n++) begin
      chk("R1 burst", int'(burst[n]), 0);
      chk("R1 bytes", int'(bytes[n]), 0);
      chk("R1 ovf",   int'(ovf[n]),   0);
    end

    txn(0, 16'h1234, 3'd0, 2, 4);
    txn(0, 16'h1235, 3'd2, 1, 3);
    txn(1, 16'h0A7F, 3'd5, 3, 2);
    txn(1, 16'h0B00, 3'd5, 1, 2);
    txn(1, 16'h0A01, 3'd4, 1, 2);
    txn(0, 16'h1234, 3'd7, 1, 10);
    chk("R2 R5 c0 bursts", int'(burst[0]), 2);
    chk("R6 c0 bytes", int'(bytes[0]), 18);
    chk("R3 R4 c1 bursts", int'(burst[1]), 1);
    chk("R6 c1 bytes", int'(bytes[1]), 6);
    chk("R4 R10 c2 bursts", int'(burst[2]), 1);
    chk("R2 c2 bytes", int'(bytes[2]), 3);

    @(negedge clk); en[0] = 0;
    txn(0, 16'h1234, 3'd0, 1, 5);
    chk("R9 c0 held", int'(burst[0]), 2);
    chk("R9 c0 bytes held", int'(bytes[0]), 18);
    @(negedge clk); en[0] = 1;
    txn(1, 16'h1234, 3'd0, 1, 5);
    chk("R3 c0 ignores write", int'(burst[0]), 2);

    txn(0, 16'h0000, 3'd2, 5, 60);
    chk("R7 c2 byte sat", int'(bytes[2]), MAXV);
    chk("R7 c2 ovf", int'(ovf[2]), 1);
    chk("R10 c0 no ovf", int'(ovf[0]), 0);
    for (int i = 0; i < 260; i++) txn(0, 16'hBEEF, 3'd2, 0, 0);
    chk("R7 c2 burst sat", int'(burst[2]), MAXV);
    chk("R7 c2 ovf sticky", int'(ovf[2]), 1);

    @(negedge clk);
    clr[2] = 1; m_addr = 1; m_wr = 0; m_id = 0; m_port = 3'd2;
    @(negedge clk);
    clr[2] = 0; m_addr = 0;
    chk("R8 c2 burst cleared", int'(burst[2]), 0);
    chk("R8 c2 bytes cleared", int'(bytes[2]), 0);
    chk("R8 c2 ovf cleared", int'(ovf[2]), 0);
    chk("R10 c0 untouched", int'(burst[0]), 2);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule